// File: doc/BRIEF.md
# Shutdown Request Pulse Decoder

This block sits on a board that takes part in a shutdown but does not start it. It watches a shared active-low, open-drain power-down line. When another board pulls that line low, the block joins in by pulling both the power-down line and a shared sync line low. It then lets go of them in a fixed order and waits for every board on the sync line to let go too. After that it reads the power-down line to tell a shutdown apart from a restart.

For a shutdown, the initiating board sends the target low-power mode as a number of low pulses on the sync line. The block counts these pulses until the line has stayed quiet for a gap timeout. It checks the count and reports the mode. A count of zero selects a configurable default mode. A count that matches no mode also selects the default mode and raises an invalid-count flag. For a restart, the count is ignored. All timing is counted in periods of an external 1 ms tick.

The result comes out as a single-cycle `result_valid_o` strobe. The mode and flags stay on their ports until the next result. There is no ready input and no back-pressure: the consumer must capture the result on the strobe cycle. The block does not drive the pads and does not enter any power mode itself.

Top module: `shutdown_pulse_decoder`

## Requirements
- R1: After reset the block is idle and armed. A low level on the synchronized power-down line starts a sequence. Both pull-low outputs go high together within 4 clock cycles of the line going low.
- R2: Both lines are pulled for HOLD_MS tick periods. The power-down pull is then released while the sync pull is held for another HOLD_MS tick periods, and then the sync pull is released. The power-down pull is never active without the sync pull.
- R3: After releasing the sync line, the block waits for as long as the sync line reads low, because another board may be holding it. It produces no result and drives no pull during this wait.
- R4: Once the sync line reads high, the block samples the power-down line once. Low gives `shutdown_o` = 1 (shutdown); high gives `shutdown_o` = 0 (restart).
- R5: Each low-then-high excursion of the sync line adds one to the pulse count; the count goes up when the line returns high. Counting ends, and the result is issued, once the line has stayed high for GAP_MS tick periods since the last pulse ended or since counting began.
- R6: For a shutdown, `mode_o` is encoded as follows: hibernate = 1, deep sleep = 2, transport = 3. A count of 1, 2 or 3 gives `mode_o` equal to the count with `count_invalid_o` = 0. A count of 0 gives DEFAULT_MODE (3 by default) with `count_invalid_o` = 0.
- R7: For a shutdown, a count above NUM_MODES (3) gives `count_invalid_o` = 1 and `mode_o` = DEFAULT_MODE.
- R8: The pulse counter saturates at 2^CNT_W-1 (7), so that extra pulses cannot wrap it back to a valid mode. For example, 9 pulses give `count_invalid_o` = 1, not hibernate.
- R9: For a restart, the pulse count is ignored: `mode_o` = 0 and `count_invalid_o` = 0.
- R10: `result_valid_o` is high for exactly one clock cycle. `mode_o`, `shutdown_o` and `count_invalid_o` are valid in that cycle and hold until the next result. Both pulls are inactive while the result is reported.
- R11: After a result, no new sequence starts until the power-down line has been seen high. A line that stays low after a shutdown does not retrigger the block.
- R12: In reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pd_line_i | input | 1 | Level read back from the shared power-down line (low = asserted) |
| sync_line_i | input | 1 | Level read back from the shared sync line (low = asserted) |
| tick_ms_i | input | 1 | One-cycle strobe every millisecond |
| pd_pull_o | output | 1 | Pull the power-down line low |
| sync_pull_o | output | 1 | Pull the sync line low |
| result_valid_o | output | 1 | One-cycle strobe: decoded result is on the ports |
| mode_o | output | MODE_W | Decoded mode (0 for a restart) |
| shutdown_o | output | 1 | 1 = shutdown requested, 0 = restart |
| count_invalid_o | output | 1 | Shutdown pulse count matched no mode |

## Verification
The bench builds the block with its default parameters: HOLD_MS = 1, GAP_MS = 10, CNT_W = 3, three modes, default mode transport. It strobes the tick every 20 clocks, so a full 10 ms gap takes about 200 cycles and every sequence fits comfortably in the run. It models both lines as wired-AND of the block's pulls and its own initiator's pulls. This covers pulse counts from zero up through the default mode, above it, and past the 3-bit saturation point. It also covers the restart case, a sync line held by another board for longer than the gap timeout, and a power-down line left low after a result.

// File: rtl/spd_pkg.sv
`timescale 1ns/1ps
package spd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_HOLD_BOTH  = 3'd1,
    ST_HOLD_SYNC  = 3'd2,
    ST_RENDEZVOUS = 3'd3,
    ST_DECIDE     = 3'd4,
    ST_WAIT_LOW   = 3'd5,
    ST_WAIT_HIGH  = 3'd6
  } spd_state_e;

  localparam int MODE_NONE      = 0;
  localparam int MODE_HIBERNATE = 1;
  localparam int MODE_DEEPSLEEP = 2;
  localparam int MODE_TRANSPORT = 3;

endpackage

// File: rtl/spd_line_sync.sv
`timescale 1ns/1ps
// Multi-bit flop-chain synchronizer; idle value of open-drain lines is high.
module spd_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain_q <= '1;
        end else begin
          chain_q <= {chain_q[STAGES-2:0], d_i[b]};
        end
      end
      assign q_o[b] = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/spd_ms_timer.sv
`timescale 1ns/1ps
// Counts tick strobes since the last clear, saturating at MAX_MS.
module spd_ms_timer #(
  parameter int MAX_MS = 10,
  localparam int TW    = $clog2(MAX_MS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          tick_i,
  output logic [TW-1:0] elapsed_o
);

  localparam logic [TW-1:0] LIMIT = TW'(MAX_MS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed_o <= '0;
    end else if (clr_i) begin
      elapsed_o <= '0;
    end else if (tick_i && (elapsed_o != LIMIT)) begin
      elapsed_o <= elapsed_o + 1'b1;
    end
  end

endmodule

// File: rtl/spd_pulse_count.sv
`timescale 1ns/1ps
// Saturating pulse counter: sticks at all-ones instead of wrapping.
module spd_pulse_count #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o <= '0;
    end else if (clr_i) begin
      count_o <= '0;
    end else if (inc_i && (count_o != '1)) begin
      count_o <= count_o + 1'b1;
    end
  end

endmodule

// File: rtl/spd_mode_resolve.sv
`timescale 1ns/1ps
// Maps a pulse count and request kind onto a mode code and an invalid flag.
module spd_mode_resolve #(
  parameter int CNT_W        = 3,
  parameter int MODE_W       = 2,
  parameter int NUM_MODES    = 3,
  parameter int DEFAULT_MODE = 3
) (
  input  logic              shutdown_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              invalid_o
);

  localparam logic [CNT_W-1:0]  TOP_CNT = CNT_W'(NUM_MODES);
  localparam logic [MODE_W-1:0] DEF_M   = MODE_W'(DEFAULT_MODE);
  localparam logic [MODE_W-1:0] NONE_M  = MODE_W'(spd_pkg::MODE_NONE);

  always_comb begin
    mode_o    = NONE_M;
    invalid_o = 1'b0;
    if (shutdown_i) begin
      if (count_i == '0) begin
        mode_o = DEF_M;
      end else if (count_i <= TOP_CNT) begin
        mode_o = MODE_W'(count_i);
      end else begin
        mode_o    = DEF_M;
        invalid_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/shutdown_pulse_decoder.sv
`timescale 1ns/1ps
module shutdown_pulse_decoder
  import spd_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int HOLD_MS      = 1,
  parameter int GAP_MS       = 10,
  parameter int CNT_W        = 3,
  parameter int MODE_W       = 2,
  parameter int NUM_MODES    = 3,
  parameter int DEFAULT_MODE = MODE_TRANSPORT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_line_i,
  input  logic              sync_line_i,
  input  logic              tick_ms_i,
  output logic              pd_pull_o,
  output logic              sync_pull_o,
  output logic              result_valid_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              shutdown_o,
  output logic              count_invalid_o
);

  localparam int TMR_MAX = (HOLD_MS > GAP_MS) ? HOLD_MS : GAP_MS;
  localparam int TW      = $clog2(TMR_MAX + 1);
  localparam logic [TW-1:0] HOLD_T = TW'(HOLD_MS);
  localparam logic [TW-1:0] GAP_T  = TW'(GAP_MS);

  // Line synchronization
  logic [1:0] lines_s;
  logic       pd_s;
  logic       sync_s;

  spd_line_sync #(
    .WIDTH (2),
    .STAGES(SYNC_STAGES)
  ) u_line_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({sync_line_i, pd_line_i}),
    .q_o  (lines_s)
  );

  assign pd_s   = lines_s[0];
  assign sync_s = lines_s[1];

  // State and shared resources
  spd_state_e        state_q, state_d;
  logic              tmr_clr;
  logic [TW-1:0]     elapsed;
  logic              cnt_clr;
  logic              cnt_inc;
  logic [CNT_W-1:0]  pulse_cnt;
  logic              armed_q;
  logic              req_shut_q;
  logic              finish;
  logic [MODE_W-1:0] res_mode;
  logic              res_inv;

  spd_ms_timer #(
    .MAX_MS(TMR_MAX)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (tmr_clr),
    .tick_i   (tick_ms_i),
    .elapsed_o(elapsed)
  );

  spd_pulse_count #(
    .CNT_W(CNT_W)
  ) u_pulse_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .count_o(pulse_cnt)
  );

  spd_mode_resolve #(
    .CNT_W       (CNT_W),
    .MODE_W      (MODE_W),
    .NUM_MODES   (NUM_MODES),
    .DEFAULT_MODE(DEFAULT_MODE)
  ) u_resolve (
    .shutdown_i(req_shut_q),
    .count_i   (pulse_cnt),
    .mode_o    (res_mode),
    .invalid_o (res_inv)
  );

  // Next-state logic
  always_comb begin
    state_d = state_q;
    finish  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (armed_q && !pd_s) state_d = ST_HOLD_BOTH;
      end
      ST_HOLD_BOTH: begin
        if (elapsed >= HOLD_T) state_d = ST_HOLD_SYNC;
      end
      ST_HOLD_SYNC: begin
        if (elapsed >= HOLD_T) state_d = ST_RENDEZVOUS;
      end
      ST_RENDEZVOUS: begin
        if (sync_s) state_d = ST_DECIDE;
      end
      ST_DECIDE: begin
        state_d = ST_WAIT_LOW;
      end
      ST_WAIT_LOW: begin
        if (!sync_s) begin
          state_d = ST_WAIT_HIGH;
        end else if (elapsed >= GAP_T) begin
          state_d = ST_IDLE;
          finish  = 1'b1;
        end
      end
      ST_WAIT_HIGH: begin
        if (sync_s) state_d = ST_WAIT_LOW;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Every state change restarts the millisecond count
  assign tmr_clr = (state_d != state_q);
  assign cnt_clr = (state_q == ST_DECIDE);
  assign cnt_inc = (state_q == ST_WAIT_HIGH) && sync_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  // Re-arm only once the power-down line has been seen released
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
    end else if (finish) begin
      armed_q <= 1'b0;
    end else if (pd_s) begin
      armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_shut_q <= 1'b0;
    end else if (state_q == ST_DECIDE) begin
      req_shut_q <= !pd_s;
    end
  end

  // Result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_valid_o  <= 1'b0;
      mode_o          <= '0;
      shutdown_o      <= 1'b0;
      count_invalid_o <= 1'b0;
    end else begin
      result_valid_o <= finish;
      if (finish) begin
        mode_o          <= res_mode;
        shutdown_o      <= req_shut_q;
        count_invalid_o <= res_inv;
      end
    end
  end

  // Pull enables decoded straight from the state register
  assign pd_pull_o   = (state_q == ST_HOLD_BOTH);
  assign sync_pull_o = (state_q == ST_HOLD_BOTH) || (state_q == ST_HOLD_SYNC);

endmodule

// File: rtl/spd_checker.sv
`timescale 1ns/1ps
module spd_checker #(
  parameter int MODE_W       = 2,
  parameter int DEFAULT_MODE = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pd_pull_o,
  input logic              sync_pull_o,
  input logic              result_valid_o,
  input logic [MODE_W-1:0] mode_o,
  input logic              shutdown_o,
  input logic              count_invalid_o
);

  localparam logic [MODE_W-1:0] DEF_M = MODE_W'(DEFAULT_MODE);

  p_pd_with_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pd_pull_o |-> sync_pull_o);

  p_pd_released_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_pull_o) |-> sync_pull_o);

  p_start_together_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_pull_o) |-> pd_pull_o);

  p_valid_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |=> !result_valid_o);

  p_quiet_on_result_r10: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |-> (!pd_pull_o && !sync_pull_o));

  p_restart_no_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid_o && !shutdown_o) |-> (mode_o == '0 && !count_invalid_o));

  p_invalid_default_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid_o && count_invalid_o) |-> (shutdown_o && mode_o == DEF_M));

  p_shutdown_has_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid_o && shutdown_o) |-> (mode_o != '0));

  p_fields_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid_o |=> (result_valid_o || $stable(mode_o)));

endmodule

bind shutdown_pulse_decoder spd_checker #(
  .MODE_W      (MODE_W),
  .DEFAULT_MODE(DEFAULT_MODE)
) u_spd_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .pd_pull_o      (pd_pull_o),
  .sync_pull_o    (sync_pull_o),
  .result_valid_o (result_valid_o),
  .mode_o         (mode_o),
  .shutdown_o     (shutdown_o),
  .count_invalid_o(count_invalid_o)
);

// File: tb/shutdown_pulse_decoder_tb.sv
`timescale 1ns/1ps
module shutdown_pulse_decoder_tb;

  localparam int T   = 20;   // clocks per millisecond tick
  localparam int GAP = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic tb_pd = 1'b0;
  logic tb_sync = 1'b0;
  logic dut_pd, dut_sync, valid, shut, inv;
  logic [1:0] mode;
  logic pd_line, sync_line;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  // wired-AND open-drain lines
  assign pd_line   = ~(dut_pd | tb_pd);
  assign sync_line = ~(dut_sync | tb_sync);

  shutdown_pulse_decoder u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .pd_line_i      (pd_line),
    .sync_line_i    (sync_line),
    .tick_ms_i      (tick),
    .pd_pull_o      (dut_pd),
    .sync_pull_o    (dut_sync),
    .result_valid_o (valid),
    .mode_o         (mode),
    .shutdown_o     (shut),
    .count_invalid_o(inv)
  );

  initial begin
    forever begin
      repeat (T - 1) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  // shut, pulses[3:0], expected mode[1:0], expected invalid
  localparam logic [7:0] VEC [9] = '{
    {1'b1, 4'd0, 2'd3, 1'b0},
    {1'b1, 4'd1, 2'd1, 1'b0},
    {1'b1, 4'd2, 2'd2, 1'b0},
    {1'b1, 4'd3, 2'd3, 1'b0},
    {1'b1, 4'd4, 2'd3, 1'b1},
    {1'b1, 4'd7, 2'd3, 1'b1},
    {1'b1, 4'd9, 2'd3, 1'b1},
    {1'b0, 4'd0, 2'd0, 1'b0},
    {1'b0, 4'd2, 2'd0, 1'b0}
  };

  task automatic run_seq(input bit sd, input int pulses, input int extra_ms,
                         input int exp_mode, input bit exp_inv);
    int c;
    bit seen;
    tb_pd = 1'b1;
    tb_sync = 1'b1;
    c = 0;
    while (!(dut_pd && dut_sync) && c < 10) begin
      @(negedge clk);
      c++;
    end
    check(dut_pd && dut_sync && c <= 4, "R1 both pulls start", c, 4);
    c = 0;
    while (dut_pd && c < 5 * T) begin
      @(negedge clk);
      c++;
    end
    check(!dut_pd && dut_sync, "R2 pd released while sync held", int'(dut_sync), 1);
    check(c >= 1 && c <= T + 2, "R2 both-pull hold length", c, T);
    if (!sd) tb_pd = 1'b0;
    c = 0;
    while (dut_sync && c < 5 * T) begin
      @(negedge clk);
      c++;
    end
    check(c >= 1 && c <= T + 2, "R2 sync-only hold length", c, T);
    seen = 0;
    repeat (extra_ms * T) begin
      @(negedge clk);
      if (valid || dut_pd || dut_sync) seen = 1;
    end
    if (extra_ms > 0) check(!seen, "R3 waits for held sync line", int'(seen), 0);
    tb_sync = 1'b0;
    repeat (T) @(negedge clk);
    for (int p = 0; p < pulses; p++) begin
      tb_sync = 1'b1;
      repeat (T) @(negedge clk);
      tb_sync = 1'b0;
      repeat (T) @(negedge clk);
    end
    c = 0;
    while (!valid && c < (GAP + 3) * T) begin
      @(negedge clk);
      c++;
    end
    check(valid, "R5 result issued after gap", int'(valid), 1);
    check(c >= (GAP - 2) * T && c <= (GAP - 1) * T + 8, "R5 gap timeout length", c, (GAP - 1) * T);
    check(shut == sd, "R4 shutdown vs restart", int'(shut), int'(sd));
    if (sd) begin
      check(mode == exp_mode, "R6 R7 R8 decoded mode", int'(mode), exp_mode);
      check(inv == exp_inv, "R7 R8 invalid flag", int'(inv), int'(exp_inv));
    end else begin
      check(mode == exp_mode && inv == exp_inv, "R9 restart ignores count", int'(mode), exp_mode);
    end
    check(!dut_pd && !dut_sync, "R10 pulls idle on result", int'(dut_sync), 0);
    @(negedge clk);
    check(!valid, "R10 valid lasts one cycle", int'(valid), 0);
    check(mode == exp_mode, "R10 mode held after strobe", int'(mode), exp_mode);
    if (sd) begin
      seen = 0;
      repeat (3 * T) begin
        @(negedge clk);
        if (valid || dut_pd || dut_sync) seen = 1;
      end
      check(!seen, "R11 no retrigger while pd held low", int'(seen), 0);
    end
    tb_pd = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!dut_pd && !dut_sync && !valid && mode == 2'd0 && !shut && !inv,
          "R12 reset state", int'({dut_pd, dut_sync, valid, shut, inv}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!dut_pd && !dut_sync && !valid, "R12 idle after reset", int'({dut_pd, dut_sync}), 0);

    foreach (VEC[i]) begin
      run_seq(VEC[i][7], int'(VEC[i][6:3]), 0, int'(VEC[i][2:1]), VEC[i][0]);
    end

    // R3: another board holds sync well beyond the gap timeout
    run_seq(1'b1, 2, GAP + 2, 2, 1'b0);
    // R11: fresh sequence works again after release
    run_seq(1'b0, 1, 1, 0, 1'b0);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R5 actual=timeout expected=done");
      summary();
      $finish;
    end
  end

endmodule